// File: doc/BRIEF.md
# DRAM Power-Up and Self-Addressed Refresh Sequencer

This block brings a multiplexed-address DRAM out of power-up and then keeps its cells refreshed. After reset it holds every strobe inactive for a fixed pause, then issues a series of refresh cycles in which the column strobes fall ahead of the row strobe, so that the device steps its own internal row counter. No row address is ever supplied, and the address, write-enable and output-enable lines carry no meaning during these cycles. Only when that series has finished does it raise `init_done`, which releases the access controller.

In normal operation an interval timer marks each refresh as owed. The block asks the access controller for the bus with `ref_req`. Once `ref_gnt` is seen while refresh is owed, it takes the bus (`bus_own` high), runs every owed refresh back to back, adds a closing row precharge, and then returns the bus. At most two refreshes can be owed. A third interval that expires before the bus is granted is dropped.

All timing is counted in clock cycles at a 10 ns period. The durations are derived from nanosecond parameters: 4 cycles of row precharge, 1 cycle of column setup, 1 cycle of column hold after the row strobe falls, and 6 cycles of row-low time, which gives an 11-cycle row period.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is held, all five strobes are high, `init_done` and `ref_req` are low, and `bus_own` is high.
- R2: After reset, no strobe falls during the first 20000 cycles (the power-up pause).
- R3: After the pause, exactly 8 refresh cycles run before `init_done` rises. `init_done` rises no earlier than 20088 and no later than 20104 cycles after reset. It never falls afterwards, and `ref_req` stays low until it rises.
- R4: In every refresh both column strobes (`lcas_n`, `ucas_n`) are already low in the cycle before `ras_n` falls, and they are still low in the first cycle `ras_n` is low. The two column strobes always carry the same level.
- R5: When a column strobe falls, `ras_n` is high and has been high for at least one earlier cycle. `ras_n` is high for at least 4 cycles before each of its falling edges.
- R6: `ras_n` stays low for at least 6 cycles, and consecutive falling edges of `ras_n` are at least 11 cycles apart.
- R7: `we_n` and `oe_n` are held high throughout every refresh cycle.
- R8: After `init_done` rises, a refresh is owed every 1600 cycles. `ref_req` first rises exactly 1600 cycles after the first cycle in which `init_done` is high.
- R9: After initialization, the strobes stay high and `bus_own` stays low until a grant is seen. If `ref_gnt` is first seen high in cycle g while refresh is owed, then `bus_own` is high from g+1 and `ras_n` first falls in cycle g+6.
- R10: At most two refreshes are owed. When the grant is withheld for three or more intervals, the next bus tenure contains exactly two refreshes.
- R11: A bus tenure performs exactly the number of refreshes owed when it began. `ras_n` is then high for at least 4 cycles before `bus_own` falls, and `ref_req` falls in the same cycle as `bus_own`.
- R12: `bus_own` is high throughout the pause and the initialization series, with no grant required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 10 ns period |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ref_req | output | 1 | Bus request: refresh owed or tenure in progress |
| init_done | output | 1 | High once the power-up series has finished |
| bus_own | output | 1 | High while this block drives the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| oe_n | output | 1 | Output enable, active low (held high) |

## Verification
The assertions assume that the access controller raises `ref_gnt` only while `ref_req` is high and drops it once `ref_req` falls. They also assume that grant latency is short compared with the 1600-cycle interval, so no new interval ends inside a tenure. The stimulus draws grant latencies of 0 to 30 cycles from a seeded generator and withdraws the grant only after the request falls. One directed window withholds the grant for more than three intervals, to drive the owed count into saturation. Expected tenure lengths come from an independent bench model of the interval timer and its two-entry cap.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_t;

    typedef enum logic [2:0] {
        E_IDLE,
        E_PRE,
        E_CSET,
        E_HOLD,
        E_RLOW,
        E_POST
    } eng_state_t;

    typedef struct packed {
        logic ras_n;
        logic lcas_n;
        logic ucas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, lcas_n: 1'b1, ucas_n: 1'b1,
                                         we_n: 1'b1, oe_n: 1'b1};

    // Round a nanosecond figure up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_refresh_timer.sv
module cbr_refresh_timer
    import cbr_refresh_pkg::*;
#(
    parameter int INTERVAL = 1600,
    parameter int MAX_OWED = 2,
    localparam int CW = $clog2(INTERVAL),
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          consume,
    output logic [OW-1:0] owed,
    output logic          tick
);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            owed <= '0;
        end else begin
            if (en) begin
                cnt <= tick ? '0 : cnt + 1'b1;
            end
            unique case ({tick, consume})
                2'b10: if (owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
                2'b01: owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assert_owed_cap_R10: assert property (@(posedge clk) disable iff (rst)
        owed <= OW'(MAX_OWED));

    assert_owed_grows_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !consume && owed < OW'(MAX_OWED)) |=> owed == $past(owed) + 1'b1);

    assert_consume_has_debt_R11: assert property (@(posedge clk) disable iff (rst)
        consume |-> (owed != '0));

endmodule

// File: rtl/cbr_strobe_engine.sv
module cbr_strobe_engine
    import cbr_refresh_pkg::*;
#(
    parameter int T_PRE  = 4,
    parameter int T_CSR  = 1,
    parameter int T_CHR  = 1,
    parameter int T_REST = 5,
    parameter int T_POST = 4,
    localparam int MAX_DUR = max_int(max_int(T_PRE, T_CSR),
                                     max_int(max_int(T_CHR, T_REST), T_POST)),
    localparam int CNT_W = $clog2(MAX_DUR + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    more,
    output strobe_t strb,
    output logic    busy,
    output logic    cyc_done,
    output logic    burst_done
);

    eng_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= E_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                E_IDLE: if (start) begin
                    state <= E_PRE;
                    cnt   <= CNT_W'(T_PRE - 1);
                end
                E_PRE: if (last) begin
                    state <= E_CSET;
                    cnt   <= CNT_W'(T_CSR - 1);
                end else cnt <= cnt - 1'b1;
                E_CSET: if (last) begin
                    state <= E_HOLD;
                    cnt   <= CNT_W'(T_CHR - 1);
                end else cnt <= cnt - 1'b1;
                E_HOLD: if (last) begin
                    state <= E_RLOW;
                    cnt   <= CNT_W'(T_REST - 1);
                end else cnt <= cnt - 1'b1;
                E_RLOW: if (last) begin
                    if (more) begin
                        state <= E_PRE;
                        cnt   <= CNT_W'(T_PRE - 1);
                    end else begin
                        state <= E_POST;
                        cnt   <= CNT_W'(T_POST - 1);
                    end
                end else cnt <= cnt - 1'b1;
                E_POST: if (last) begin
                    state <= E_IDLE;
                end else cnt <= cnt - 1'b1;
                default: state <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        strb = STROBE_IDLE;
        unique case (state)
            E_CSET: begin
                strb.lcas_n = 1'b0;
                strb.ucas_n = 1'b0;
            end
            E_HOLD: begin
                strb.ras_n  = 1'b0;
                strb.lcas_n = 1'b0;
                strb.ucas_n = 1'b0;
            end
            E_RLOW: strb.ras_n = 1'b0;
            default: strb = STROBE_IDLE;
        endcase
    end

    assign busy       = (state != E_IDLE);
    assign cyc_done   = (state == E_RLOW) && last;
    assign burst_done = (state == E_POST) && last;

    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |-> (!$past(strb.lcas_n) && !$past(strb.ucas_n)
                               && !strb.lcas_n && !strb.ucas_n));

    assert_ras_low_two_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |=> !strb.ras_n);

    assert_cas_fall_ras_high_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.lcas_n) |-> (strb.ras_n && $past(strb.ras_n)));

    assert_release_high_R11: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> (strb.ras_n && $past(strb.ras_n)));

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
    import cbr_refresh_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int PAUSE_NS  = 200000,
    parameter int INIT_N    = 8,
    parameter int INTERVAL  = 1600,
    parameter int MAX_OWED  = 2,
    parameter int T_RP_NS   = 40,
    parameter int T_CSR_NS  = 0,
    parameter int T_CHR_NS  = 10,
    parameter int T_RAS_NS  = 60,
    parameter int T_RC_NS   = 104
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic init_done,
    output logic bus_own,
    output logic ras_n,
    output logic lcas_n,
    output logic ucas_n,
    output logic we_n,
    output logic oe_n
);

    localparam int PAUSE_CYC = ns_to_cycles(PAUSE_NS, CLK_NS);
    localparam int T_PRE     = ns_to_cycles(T_RP_NS, CLK_NS);
    localparam int T_CSR     = ns_to_cycles(T_CSR_NS, CLK_NS);
    localparam int T_CHR     = ns_to_cycles(T_CHR_NS, CLK_NS);
    localparam int T_RAS     = ns_to_cycles(T_RAS_NS, CLK_NS);
    localparam int T_RC      = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int T_RLOW    = max_int(max_int(T_RAS, T_RC - T_PRE - T_CSR), T_CHR + 1);
    localparam int T_REST    = T_RLOW - T_CHR;
    localparam int PW        = $clog2(PAUSE_CYC);
    localparam int IW        = $clog2(INIT_N + 1);
    localparam int OW        = $clog2(MAX_OWED + 1);

    phase_t        phase;
    logic [PW-1:0] pcnt;
    logic [IW-1:0] icnt;
    logic [OW-1:0] owed;
    logic          tick, consume, start, more;
    logic          busy, cyc_done, burst_done;
    logic          pause_end;
    strobe_t       strb;

    assign pause_end = (phase == PH_PAUSE) && (pcnt == PW'(PAUSE_CYC - 1));
    assign consume   = (phase == PH_RUN) && cyc_done;
    assign start     = pause_end ||
                       ((phase == PH_RUN) && !busy && (owed != '0) && ref_gnt);
    assign more      = (phase == PH_INIT) ? (icnt != IW'(INIT_N - 1))
                                          : ((owed > OW'(1)) || tick);

    cbr_refresh_timer #(
        .INTERVAL (INTERVAL),
        .MAX_OWED (MAX_OWED)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (phase == PH_RUN),
        .consume (consume),
        .owed    (owed),
        .tick    (tick)
    );

    cbr_strobe_engine #(
        .T_PRE  (T_PRE),
        .T_CSR  (T_CSR),
        .T_CHR  (T_CHR),
        .T_REST (T_REST),
        .T_POST (T_PRE)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .more       (more),
        .strb       (strb),
        .busy       (busy),
        .cyc_done   (cyc_done),
        .burst_done (burst_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_PAUSE;
            pcnt  <= '0;
            icnt  <= '0;
        end else begin
            unique case (phase)
                PH_PAUSE: begin
                    if (pause_end) phase <= PH_INIT;
                    else           pcnt  <= pcnt + 1'b1;
                end
                PH_INIT: begin
                    if (cyc_done)   icnt  <= icnt + 1'b1;
                    if (burst_done) phase <= PH_RUN;
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    assign init_done = (phase == PH_RUN);
    assign ref_req   = (phase == PH_RUN) && ((owed != '0) || busy);
    assign bus_own   = (phase != PH_RUN) || busy;
    assign ras_n     = strb.ras_n;
    assign lcas_n    = strb.lcas_n;
    assign ucas_n    = strb.ucas_n;
    assign we_n      = strb.we_n;
    assign oe_n      = strb.oe_n;

    assert_no_req_in_init_R3: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !ref_req);

    assert_init_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_idle_strobes_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_own |-> (ras_n && lcas_n && ucas_n));

    assert_tenure_needs_grant_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_own) && init_done) |-> $past(ref_gnt));

    assert_init_owns_bus_R12: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> bus_own);

    assert_req_drops_with_bus_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_own) && $past(init_done)) |-> !ref_req || tick);

endmodule

// File: tb/cbr_refresh_seq_tb.sv
module cbr_refresh_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PAUSE_CYC  = 20000;
    localparam int INIT_N     = 8;
    localparam int INTERVAL   = 1600;
    localparam int MAX_OWED   = 2;
    localparam int RP_MIN     = 4;
    localparam int RAS_MIN    = 6;
    localparam int RC_MIN     = 11;
    localparam int GNT_TO_RAS = 6;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, init_done, bus_own, ras_n, lcas_n, ucas_n, we_n, oe_n;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cbr_refresh_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .ref_gnt   (ref_gnt),
        .ref_req   (ref_req),
        .init_done (init_done),
        .bus_own   (bus_own),
        .ras_n     (ras_n),
        .lcas_n    (lcas_n),
        .ucas_n    (ucas_n),
        .we_n      (we_n),
        .oe_n      (oe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v >= MAX_OWED) ? MAX_OWED : v + 1;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Monitor and grant model state
    bit mon_on = 1'b0;
    bit hold_off = 1'b0;
    int cyc = 0;
    bit p_ras = 1'b1, p_cas = 1'b1, p_own = 1'b1, p_init = 1'b0, p_req = 1'b0;
    int ras_hi_run = 0, ras_lo_run = 0, cas_hi_run = 0;
    int last_fall = -1;
    int first_fall = -1;
    int init_refs = 0;
    bit init_viol = 1'b0;
    int run_cyc = -1;
    bit req_seen = 1'b0;
    int owed_m = 0;
    int exp_burst = 0;
    int burst_refs = 0;
    bit first_in_burst = 1'b0;
    int exp_ras = -1;
    int lat = 0;
    bit saw_double = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            // R4: column strobes move together
            if (lcas_n != ucas_n) chk(1'b0, "R4 lcas/ucas split", lcas_n, ucas_n);
            if (!init_done) begin
                if (ref_req || !bus_own) init_viol = 1'b1;
            end

            // Column strobe falling edge
            if (p_cas && !lcas_n) begin
                chk(ras_n && ras_hi_run >= 1 && cas_hi_run >= 1, "R5 cas fall precharge",
                    ras_hi_run, 1);
            end

            // Row strobe falling edge
            if (p_ras && !ras_n) begin
                if (first_fall < 0) begin
                    first_fall = cyc;
                    chk(cyc >= PAUSE_CYC, "R2 pause kept", cyc, PAUSE_CYC);
                end
                chk(!p_cas && !lcas_n && !ucas_n, "R4 cas before ras", lcas_n, 0);
                chk(ras_hi_run >= RP_MIN, "R5 ras precharge", ras_hi_run, RP_MIN);
                if (last_fall >= 0)
                    chk(cyc - last_fall >= RC_MIN, "R6 ras period", cyc - last_fall, RC_MIN);
                chk(we_n && oe_n, "R7 we/oe high", {we_n, oe_n}, 3);
                last_fall = cyc;
                if (!init_done) init_refs++;
                else begin
                    burst_refs++;
                    if (first_in_burst) begin
                        chk(cyc == exp_ras, "R9 grant to ras", cyc, exp_ras);
                        first_in_burst = 1'b0;
                    end
                end
            end

            // Row strobe rising edge
            if (!p_ras && ras_n)
                chk(ras_lo_run >= RAS_MIN, "R6 ras width", ras_lo_run, RAS_MIN);

            // init_done rise
            if (init_done && !p_init) begin
                chk(init_refs == INIT_N, "R3 init refresh count", init_refs, INIT_N);
                chk(cyc >= PAUSE_CYC + INIT_N * RC_MIN && cyc <= PAUSE_CYC + INIT_N * RC_MIN + 16,
                    "R3 init_done time", cyc, PAUSE_CYC + INIT_N * RC_MIN);
                chk(!init_viol, "R3/R12 req low and bus owned in init", init_viol, 0);
                run_cyc = 0;
            end
            if (!init_done && p_init) chk(1'b0, "R3 init_done fell", 0, 1);

            // Running phase
            if (init_done && p_init) begin
                if (!p_own && bus_own) begin
                    exp_burst = owed_m;
                    owed_m = 0;
                    burst_refs = 0;
                    first_in_burst = 1'b1;
                end
                if (p_own && !bus_own) begin
                    chk(burst_refs == exp_burst, "R10/R11 refreshes per tenure",
                        burst_refs, exp_burst);
                    chk(!ref_req, "R11 req with release", ref_req, 0);
                    chk(ras_hi_run >= RP_MIN, "R11 closing precharge", ras_hi_run, RP_MIN);
                    if (burst_refs == 2) saw_double = 1'b1;
                end
                if (!bus_own && !ref_gnt && (!ras_n || !lcas_n))
                    chk(1'b0, "R9 strobe without grant", ras_n, 1);
            end
            if (init_done) begin
                if (!req_seen && ref_req) begin
                    req_seen = 1'b1;
                    chk(run_cyc == INTERVAL, "R8 first request", run_cyc, INTERVAL);
                end
                if (run_cyc % INTERVAL == INTERVAL - 1) owed_m = sat_inc(owed_m);
                run_cyc++;
            end

            // Run-length bookkeeping
            ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
            ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
            cas_hi_run = lcas_n ? cas_hi_run + 1 : 0;
            p_ras  = ras_n;
            p_cas  = lcas_n;
            p_own  = bus_own;
            p_init = init_done;
            p_req  = ref_req;

            // Grant model
            if (!ref_req && ref_gnt) begin
                ref_gnt = 1'b0;
                lat = $urandom_range(0, 30);
            end else if (init_done && ref_req && !ref_gnt && !hold_off) begin
                if (lat == 0) begin
                    ref_gnt = 1'b1;
                    exp_ras = cyc + GNT_TO_RAS;
                end else lat--;
            end
            cyc++;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        lat = $urandom_range(0, 30);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(ras_n && lcas_n && ucas_n && we_n && oe_n, "R1 strobes high in reset",
            {ras_n, lcas_n, ucas_n, we_n, oe_n}, 31);
        chk(!init_done && !ref_req, "R1 init_done/req low", {init_done, ref_req}, 0);
        chk(bus_own, "R1 bus owned", bus_own, 1);
        @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);
        mon_on = 1'b1;

        wait (init_done);
        wait (req_seen);
        repeat (10 * INTERVAL) @(negedge clk);

        // R10: withhold the grant across three intervals
        while (ref_req || bus_own) @(negedge clk);
        hold_off = 1'b1;
        repeat (3 * INTERVAL + 50) @(negedge clk);
        chk(bus_own == 1'b0 && ras_n, "R9 idle while grant withheld", bus_own, 0);
        hold_off = 1'b0;
        repeat (4 * INTERVAL) @(negedge clk);

        chk(saw_double, "R10 saturated tenure seen", saw_double, 1);
        chk(first_fall >= PAUSE_CYC, "R2 first ras fall", first_fall, PAUSE_CYC);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            finish_run();
        end
    end

endmodule